// File: doc/BRIEF.md
# Virtual Address Permission Checker

This block sits between the address generator of a load/store pipe and the memory interface. It takes a 32-bit virtual address together with the access type, the privilege level and three control bits: translation enable, single-virtual mode and a store-queue user lock. From these it decides whether the address is forwarded without translation, forwarded with its top three bits cleared, translated, or rejected.

For a translated access, an external lookup array provides the result in the same cycle. That result is a hit or multi-hit indication plus the matched entry's flags, page number and page mask. The block asks the array for ASID matching through a combinational hint. It applies the protection and dirty rules and forms the physical address. It registers either that address or exactly one exception code. On faults that come from the lookup, it also captures the faulting address. It loads the page-number field of the page-table-entry-high register and leaves that register's low ten bits intact.

Top module: `va_perm_checker`

## Requirements
- R1: In privileged mode, an address with bits 31:29 = 111 is forwarded unchanged. An address with bits 31:30 = 10 is forwarded ANDed with 0x1FFFFFFF.
- R2: In user mode, an address with bit 31 set gives code 1 for a read or code 2 for a write. The exception is an address with bits 31:26 = 111000 while `ctl_sq_lock` is 0; that address is forwarded unchanged.
- R3: When `ctl_xlat_en` is 0, every address not covered by R1/R2 is forwarded ANDed with 0x1FFFFFFF. This includes privileged addresses with bits 31:29 = 110.
- R4: `lk_match_asid` is 0 only for a privileged access with `ctl_single_virt` = 1. Otherwise it is 1.
- R5: A translated access with `lk_hit`=0 and `lk_multi`=0 gives code 3 for a read or code 4 for a write. `lk_multi`=1 gives code 5 with `exc_reset`=1. `exc_reset` is 0 for every other code.
- R6: A user read to an entry whose flag bit 6 (user access) is clear gives code 6. A privileged read ignores bit 6.
- R7: A privileged write to an entry with flag bit 5 (writable) clear gives code 7. A user write gives code 7 unless flag bits 5 and 6 are both set.
- R8: A write that passes R7 but finds flag bit 2 (dirty) clear gives code 8. A write that fails R7 reports code 7, not 8.
- R9: A translated access with no fault returns (`lk_ppn` AND `lk_mask`) OR (VA AND NOT `lk_mask`).
- R10: On codes 3 to 8, `tea_q` takes the VA and `pteh_q` takes VA[31:10] above its kept bits 9:0. Codes 1 and 2 and successful accesses leave both unchanged. `pteh_ld` writes `pteh_q` whole.
- R11: The results appear one cycle after `req_valid`. They are `rsp_ok` with `rsp_pa`, or `rsp_exc` with `exc_code`, never both. Each is a one-cycle strobe, and there is none without a request. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| ctl_xlat_en | input | 1 | Address translation enable |
| ctl_single_virt | input | 1 | Single-virtual mode |
| ctl_sq_lock | input | 1 | 1 = store-queue window closed to user mode |
| lk_match_asid | output | 1 | Lookup must compare ASID |
| lk_hit | input | 1 | Lookup found exactly one entry |
| lk_multi | input | 1 | Lookup found several entries |
| lk_flags | input | 9 | Matched entry flags |
| lk_ppn | input | 32 | Matched entry physical page number |
| lk_mask | input | 32 | Matched entry page mask |
| pteh_ld | input | 1 | Load whole page-table-entry-high register |
| pteh_ld_data | input | 32 | Data for that load |
| rsp_ok | output | 1 | Physical address strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_exc | output | 1 | Exception strobe |
| exc_code | output | 4 | Exception code (1..8) |
| exc_reset | output | 1 | Exception is reset-class |
| tea_q | output | 32 | Fault address register |
| pteh_q | output | 32 | Page-table-entry-high register |

## Verification
The `lk_match_asid` hint is combinational, so it is checked about 1 ns after its inputs change, with no clock edge in between. Every other result is registered once. The bench therefore presents an access at a falling edge and reads the strobe, code and address 1 ns after the next rising edge. It reads `tea_q` and `pteh_q` at that same point. It then drops `req_valid` and checks one cycle later that the strobe has cleared. When it checks that an address error leaves the fault registers alone, it reads them in the cycle after that error.

// File: rtl/vapc_pkg.sv
// Shared types for the virtual address permission checker.
// Assumes a 9-bit entry flag field with user, writable and dirty bits
// at the positions given below.
package vapc_pkg;
    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ADDR_RD = 4'd1,
        EXC_ADDR_WR = 4'd2,
        EXC_MISS_RD = 4'd3,
        EXC_MISS_WR = 4'd4,
        EXC_MULTI   = 4'd5,
        EXC_PROT_RD = 4'd6,
        EXC_PROT_WR = 4'd7,
        EXC_INIT_WR = 4'd8
    } exc_e;

    typedef enum logic [1:0] {
        ROUTE_RAW   = 2'd0,
        ROUTE_MASK  = 2'd1,
        ROUTE_XLAT  = 2'd2,
        ROUTE_ADERR = 2'd3
    } route_e;

    localparam int FLAG_W   = 9;
    localparam int FL_USER  = 6;
    localparam int FL_WRITE = 5;
    localparam int FL_DIRTY = 2;
endpackage

// File: rtl/vapc_region.sv
// Region classifier: decides from the address, the privilege level and the
// control bits whether an access is forwarded raw, forwarded with its top
// three bits cleared, translated, or rejected. Purely combinational.
module vapc_region
    import vapc_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    input  logic            xlat_en,
    input  logic            sq_lock,
    output route_e          route
);
    localparam int MSB = VA_W - 1;

    logic top_high, top_kern, top_sq;
    assign top_high = (va[MSB -: 3] == 3'b111);
    assign top_kern = (va[MSB -: 2] == 2'b10);
    assign top_sq   = (va[MSB -: 6] == 6'b111000);

    // Pick the route for the access.
    always_comb begin
        route = xlat_en ? ROUTE_XLAT : ROUTE_MASK;
        if (va[MSB]) begin
            if (priv) begin
                if (top_high)      route = ROUTE_RAW;
                else if (top_kern) route = ROUTE_MASK;
            end else begin
                route = (top_sq && !sq_lock) ? ROUTE_RAW : ROUTE_ADERR;
            end
        end
    end
endmodule

// File: rtl/vapc_protect.sv
// Lookup result and protection evaluation for a translated access.
// Assumes hit and multi are never both meaningful; multi takes effect
// when set. Purely combinational.
module vapc_protect
    import vapc_pkg::*;
(
    input  logic              write,
    input  logic              priv,
    input  logic              hit,
    input  logic              multi,
    input  logic [FLAG_W-1:0] flags,
    output exc_e              code
);
    logic fl_u, fl_w, fl_d, wr_ok;
    assign fl_u  = flags[FL_USER];
    assign fl_w  = flags[FL_WRITE];
    assign fl_d  = flags[FL_DIRTY];
    assign wr_ok = priv ? fl_w : (fl_w && fl_u);

    // Rank the faults: miss, multi-hit, protection, initial write.
    always_comb begin
        code = EXC_NONE;
        if (!hit && !multi)     code = write ? EXC_MISS_WR : EXC_MISS_RD;
        else if (multi)         code = EXC_MULTI;
        else if (write) begin
            if (!wr_ok)         code = EXC_PROT_WR;
            else if (!fl_d)     code = EXC_INIT_WR;
        end else if (!priv && !fl_u) begin
            code = EXC_PROT_RD;
        end
    end
endmodule

// File: rtl/vapc_fault_regs.sv
// Fault address and page-table-entry-high registers. A lookup fault loads
// the address into the first and its page bits into the second, keeping
// the low KEEP_W bits. A direct load writes the second register whole.
module vapc_fault_regs #(
    parameter int VA_W   = 32,
    parameter int KEEP_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_ld,
    input  logic [VA_W-1:0] fault_va,
    input  logic            pteh_ld,
    input  logic [VA_W-1:0] pteh_ld_data,
    output logic [VA_W-1:0] tea_q,
    output logic [VA_W-1:0] pteh_q
);
    // Update both registers on a fault or a direct load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tea_q  <= '0;
            pteh_q <= '0;
        end else if (fault_ld) begin
            tea_q  <= fault_va;
            pteh_q <= {fault_va[VA_W-1:KEEP_W], pteh_q[KEEP_W-1:0]};
        end else if (pteh_ld) begin
            pteh_q <= pteh_ld_data;
        end
    end
endmodule

// File: rtl/va_perm_checker.sv
// Virtual address permission checker top. Classifies each access, applies
// the lookup and protection rules, and registers one result per access:
// a physical address or one exception code. Assumes the lookup array
// answers combinationally in the request cycle.
module va_perm_checker
    import vapc_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int KEEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              ctl_xlat_en,
    input  logic              ctl_single_virt,
    input  logic              ctl_sq_lock,
    output logic              lk_match_asid,
    input  logic              lk_hit,
    input  logic              lk_multi,
    input  logic [FLAG_W-1:0] lk_flags,
    input  logic [VA_W-1:0]   lk_ppn,
    input  logic [VA_W-1:0]   lk_mask,
    input  logic              pteh_ld,
    input  logic [VA_W-1:0]   pteh_ld_data,
    output logic              rsp_ok,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_exc,
    output logic [3:0]        exc_code,
    output logic              exc_reset,
    output logic [VA_W-1:0]   tea_q,
    output logic [VA_W-1:0]   pteh_q
);
    localparam logic [VA_W-1:0] EXT_MASK = {3'b000, {(VA_W-3){1'b1}}};

    route_e    route;
    exc_e      xl_code, nxt_code;
    logic [VA_W-1:0] nxt_pa;
    logic      tlb_fault;

    vapc_region #(.VA_W(VA_W)) u_region (
        .va(req_va), .priv(req_priv), .xlat_en(ctl_xlat_en),
        .sq_lock(ctl_sq_lock), .route(route)
    );

    vapc_protect u_protect (
        .write(req_write), .priv(req_priv), .hit(lk_hit),
        .multi(lk_multi), .flags(lk_flags), .code(xl_code)
    );

    // Tell the lookup whether the ASID takes part in the match.
    assign lk_match_asid = !(req_priv && ctl_single_virt);

    // Merge the route and the translated outcome into one result.
    always_comb begin
        nxt_code = EXC_NONE;
        nxt_pa   = req_va;
        unique case (route)
            ROUTE_RAW:   nxt_pa = req_va;
            ROUTE_MASK:  nxt_pa = req_va & EXT_MASK;
            ROUTE_ADERR: nxt_code = req_write ? EXC_ADDR_WR : EXC_ADDR_RD;
            ROUTE_XLAT: begin
                nxt_code = xl_code;
                nxt_pa   = (lk_ppn & lk_mask) | (req_va & ~lk_mask);
            end
            default:     nxt_code = EXC_NONE;
        endcase
    end

    assign tlb_fault = req_valid && (route == ROUTE_XLAT) && (xl_code != EXC_NONE);

    // Register the response strobes, code and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok    <= 1'b0;
            rsp_exc   <= 1'b0;
            exc_code  <= 4'd0;
            exc_reset <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_ok    <= req_valid && (nxt_code == EXC_NONE);
            rsp_exc   <= req_valid && (nxt_code != EXC_NONE);
            exc_code  <= req_valid ? 4'(nxt_code) : 4'd0;
            exc_reset <= req_valid && (nxt_code == EXC_MULTI);
            rsp_pa    <= (req_valid && nxt_code == EXC_NONE) ? nxt_pa : '0;
        end
    end

    vapc_fault_regs #(.VA_W(VA_W), .KEEP_W(KEEP_W)) u_fregs (
        .clk(clk), .rst_n(rst_n), .fault_ld(tlb_fault), .fault_va(req_va),
        .pteh_ld(pteh_ld), .pteh_ld_data(pteh_ld_data),
        .tea_q(tea_q), .pteh_q(pteh_q)
    );
endmodule

// File: rtl/vapc_chk.sv
// Assertion checker for va_perm_checker, bound to every instance.
module vapc_chk #(
    parameter int VA_W   = 32,
    parameter int KEEP_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            pteh_ld,
    input logic            rsp_ok,
    input logic            rsp_exc,
    input logic [3:0]      exc_code,
    input logic            exc_reset,
    input logic [VA_W-1:0] tea_q,
    input logic [VA_W-1:0] pteh_q
);
    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_ok, rsp_exc}));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_ok || rsp_exc));
    // R5
    reset_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_reset |-> (rsp_exc && exc_code == 4'd5));
    // R10
    tea_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tea_q) |-> (rsp_exc && exc_code >= 4'd3));
    // R10
    pteh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pteh_ld) |-> $stable(pteh_q[KEEP_W-1:0]));
endmodule

bind va_perm_checker vapc_chk #(.VA_W(VA_W), .KEEP_W(KEEP_W)) u_vapc_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pteh_ld(pteh_ld),
    .rsp_ok(rsp_ok), .rsp_exc(rsp_exc), .exc_code(exc_code),
    .exc_reset(exc_reset), .tea_q(tea_q), .pteh_q(pteh_q)
);

// File: tb/test_va_perm_checker.sv
`timescale 1ns/1ps
module test_va_perm_checker;
    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, req_priv = 0;
    logic [31:0] req_va = 0;
    logic        ctl_xlat_en = 0, ctl_single_virt = 0, ctl_sq_lock = 0;
    logic        lk_match_asid, lk_hit = 0, lk_multi = 0;
    logic [8:0]  lk_flags = 0;
    logic [31:0] lk_ppn = 0, lk_mask = 0;
    logic        pteh_ld = 0;
    logic [31:0] pteh_ld_data = 0;
    logic        rsp_ok, rsp_exc, exc_reset;
    logic [31:0] rsp_pa, tea_q, pteh_q;
    logic [3:0]  exc_code;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    va_perm_checker i_va_perm_checker (.*);

    typedef struct packed {
        logic [31:0] va;
        logic wr, pv, xen, sql, hit, mul;
        logic [8:0]  fl;
        logic [31:0] ppn, mask;
        logic [3:0]  code;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'hF0001234,0,1,1,0,0,0,9'h000,32'h0,32'h0,4'd0,32'hF0001234}, // R1
        '{32'h9ABCDEF0,1,1,1,0,0,0,9'h000,32'h0,32'h0,4'd0,32'h1ABCDEF0}, // R1
        '{32'h80000000,0,0,1,0,0,0,9'h000,32'h0,32'h0,4'd1,32'h0},        // R2
        '{32'hE2000040,1,0,1,0,0,0,9'h000,32'h0,32'h0,4'd0,32'hE2000040}, // R2
        '{32'hE2000040,1,0,1,1,0,0,9'h000,32'h0,32'h0,4'd2,32'h0},        // R2
        '{32'hC1234567,0,1,0,0,0,0,9'h000,32'h0,32'h0,4'd0,32'h01234567}, // R3
        '{32'h7FFF0000,1,0,0,0,0,0,9'h000,32'h0,32'h0,4'd0,32'h1FFF0000}, // R3
        '{32'h00401000,0,0,1,0,0,0,9'h164,32'h0,32'hFFFFF000,4'd3,32'h0}, // R5
        '{32'h00401000,1,0,1,0,0,0,9'h164,32'h0,32'hFFFFF000,4'd4,32'h0}, // R5
        '{32'h00401000,0,1,1,0,0,1,9'h164,32'h0,32'hFFFFF000,4'd5,32'h0}, // R5
        '{32'h00401000,0,0,1,0,1,0,9'h124,32'h0,32'hFFFFF000,4'd6,32'h0}, // R6
        '{32'h00401000,1,1,1,0,1,0,9'h144,32'h0,32'hFFFFF000,4'd7,32'h0}, // R7
        '{32'h00401000,1,0,1,0,1,0,9'h124,32'h0,32'hFFFFF000,4'd7,32'h0}, // R7
        '{32'h00401000,1,1,1,0,1,0,9'h120,32'h0,32'hFFFFF000,4'd8,32'h0}, // R8
        '{32'h00401000,1,0,1,0,1,0,9'h100,32'h0,32'hFFFFF000,4'd7,32'h0}, // R8
        '{32'h00403ABC,0,1,1,0,1,0,9'h100,32'h0C000000,32'hFFFFF000,4'd0,32'h0C000ABC}, // R9
        '{32'h12345678,1,0,1,0,1,0,9'h164,32'h0ABC0000,32'hFFFF0000,4'd0,32'h0ABC5678}  // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_valid = 1; req_va = v.va; req_write = v.wr; req_priv = v.pv;
        ctl_xlat_en = v.xen; ctl_sq_lock = v.sql;
        lk_hit = v.hit; lk_multi = v.mul; lk_flags = v.fl;
        lk_ppn = v.ppn; lk_mask = v.mask;
        @(posedge clk); #1;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset ok", {31'd0, rsp_ok}, 0);
        check("R11 reset exc", {31'd0, rsp_exc}, 0);
        check("R10 reset tea", tea_q, 0);
        @(negedge clk); rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1; req_va = VECS[i].va; req_write = VECS[i].wr;
            req_priv = VECS[i].pv; ctl_xlat_en = VECS[i].xen;
            ctl_sq_lock = VECS[i].sql; lk_hit = VECS[i].hit;
            lk_multi = VECS[i].mul; lk_flags = VECS[i].fl;
            lk_ppn = VECS[i].ppn; lk_mask = VECS[i].mask;
            @(posedge clk); #1;
            check($sformatf("vec%0d code", i), {28'd0, exc_code}, {28'd0, VECS[i].code});
            check($sformatf("vec%0d exc", i), {31'd0, rsp_exc}, {31'd0, VECS[i].code != 0});
            check($sformatf("vec%0d ok", i), {31'd0, rsp_ok}, {31'd0, VECS[i].code == 0});
            check($sformatf("vec%0d R5 reset", i), {31'd0, exc_reset}, {31'd0, VECS[i].code == 5});
            if (VECS[i].code == 0) check($sformatf("vec%0d pa", i), rsp_pa, VECS[i].pa);
            @(negedge clk); req_valid = 0;
            @(posedge clk); #1;
            check("R11 strobe drops", {30'd0, rsp_ok, rsp_exc}, 0);
        end

        // R4: ASID hint
        @(negedge clk);
        req_priv = 1; ctl_single_virt = 1; #1;
        check("R4 priv sv", {31'd0, lk_match_asid}, 0);
        req_priv = 0; #1;
        check("R4 user sv", {31'd0, lk_match_asid}, 1);
        req_priv = 1; ctl_single_virt = 0; #1;
        check("R4 priv nosv", {31'd0, lk_match_asid}, 1);

        // R10: fault registers
        @(negedge clk);
        pteh_ld = 1; pteh_ld_data = 32'h000003A5;
        @(negedge clk); pteh_ld = 0;
        check("R10 pteh load", pteh_q, 32'h000003A5);
        apply('{32'h12345678,0,0,1,0,0,0,9'h164,32'h0,32'hFFFFF000,4'd3,32'h0});
        check("R10 tea on miss", tea_q, 32'h12345678);
        check("R10 pteh on miss", pteh_q, 32'h123457A5);
        apply('{32'h80000000,0,0,1,0,0,0,9'h000,32'h0,32'h0,4'd1,32'h0});
        check("R10 tea kept on addr err", tea_q, 32'h12345678);
        check("R10 pteh kept on addr err", pteh_q, 32'h123457A5);
        apply('{32'h00403ABC,0,1,1,0,1,0,9'h100,32'h0C000000,32'hFFFFF000,4'd0,32'h0});
        check("R10 tea kept on success", tea_q, 32'h12345678);

        // R11: back-to-back accesses each give one strobe
        @(negedge clk);
        req_valid = 1; req_priv = 1; req_va = 32'hF0000000; req_write = 0;
        @(posedge clk); #1;
        check("R11 first ok", {31'd0, rsp_ok}, 1);
        @(negedge clk); req_priv = 0; req_va = 32'h80000000;
        @(posedge clk); #1;
        check("R11 second exc", {30'd0, rsp_ok, rsp_exc}, 1);
        check("R2 second code", {28'd0, exc_code}, 1);
        @(negedge clk); req_valid = 0;
        @(posedge clk); #1;
        check("R11 idle", {30'd0, rsp_ok, rsp_exc}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule